// File: doc/BRIEF.md
# PRBS Bit-Error-Rate Engine

This block measures the error rate of a parallel transceiver datapath. Its transmit side emits one 32-bit test word per clock. The word comes either from one of four maximal-length pseudo-random sequences or from one of two fixed clock-like patterns. Its receive side takes the words that came back over the link. A follower register seeds itself from those words and, once it trusts the stream, predicts every next word. The words are then compared bit by bit against the prediction.

While the follower is locked, the block adds the mismatching bits to a bit-error total and 32 to a total-bits count. It also counts frames that held at least one error, and raises a one-cycle pulse for every word that had an error. Software computes the error rate as bit errors divided by total bits. The generator and the statistics have restarts that are separate from the global reset, so a run can begin again without disturbing the link.

The pattern select `pat_sel` is decoded as follows. When bit 2 is 0, bits 1:0 pick a sequence: 0 is x^7+x^6+1, 1 is x^15+x^14+1, 2 is x^23+x^18+1 and 3 is x^31+x^28+1. When bit 2 is 1, bit 0 picks a clock word: 0 gives 0xAAAAAAAA and 1 gives 0xFFFF0000, and bit 1 is ignored.

Top module: `bert_engine`

## Requirements
- R1: In a sequence mode, bit 31 of each transmit word holds the earliest of 32 successive sequence bits and bit 0 holds the latest. The next word continues the same sequence with no gap, and the low N bits of a word (N being the polynomial degree) are the generator state after that word.
- R2: `pat_sel` codes 4 and 6 transmit 0xAAAAAAAA on every cycle, and codes 5 and 7 transmit 0xFFFF0000 on every cycle.
- R3: While `gen_rst` or `rst` is high the transmit word is 0. The first word after release is the one generated from an all-ones state of N bits, and it appears one clock later.
- R4: While unlocked, a valid word that differs from the prediction reseeds the follower from its own low N bits. After LOCK_RUN (16) consecutive matching valid words, `locked` is high one cycle after the last of them.
- R5: Valid words seen while locked are grouped into windows of LOSS_WIN (64) words, counted from the word after lock. A window that reaches LOSS_ERRS (8) errored words drops lock after that word, and the follower reseeds from that word. Fewer errored words per window keep lock.
- R6: Each valid word received while locked adds the number of set bits of (received XOR predicted) to `bit_errs`. Words received while unlocked add nothing.
- R7: Each valid word received while locked adds 32 to `total_bits`.
- R8: `err_pulse` is high for exactly one cycle, one cycle after a locked valid word that had at least one bit error. It is low for every other word.
- R9: Frames are FRAME_WORDS locked valid words long, counted from lock acquisition. `frame_errs` rises by one at the last word of each frame that held any bit error.
- R10: All three counters stop at their all-ones value instead of wrapping.
- R11: `stat_clr` zeroes the counters, the frame position and the pulse one cycle later. It leaves `locked` and the prediction untouched.
- R12: Cycles with `rx_valid` low do not advance the prediction and do not change the counters or the lock.
- R13: After `rst`, `locked`, `err_pulse`, all counters and `tx_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the whole block |
| gen_rst | input | 1 | Synchronous restart of the transmit generator |
| stat_clr | input | 1 | Synchronous clear of the statistics |
| pat_sel | input | 3 | Pattern select, shared by transmitter and follower |
| rx_data | input | 32 | Received word |
| rx_valid | input | 1 | Qualifies `rx_data` |
| tx_data | output | 32 | Registered transmit word |
| bit_errs | output | CNT_W | Saturating bit-error count |
| frame_errs | output | CNT_W | Saturating count of errored frames |
| total_bits | output | CNT_W | Saturating count of compared bits |
| locked | output | 1 | Follower lock flag |
| err_pulse | output | 1 | One-cycle flag for an errored locked word |

## Verification
Every result is due one clock after the edge that takes in its stimulus. That holds for the transmit word after a generator restart, for counter and pulse updates after a received word, for `locked` after the 16th matching word or the 8th errored one, and for the zeroed counters after a clear. Each scenario drives its inputs on the falling edge and samples one time unit after the rising edge that consumes them, so every check reads the value from the edge that produced it. Scenarios that count runs of words (lock, window, frame, saturation) check one word before each threshold and one word at it, which pins the threshold to the exact word.

// File: rtl/bert_pkg.sv
package bert_pkg;
  localparam int WORD_W = 32;
  localparam int LFSR_W = 31;
  localparam int POPC_W = $clog2(WORD_W + 1);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LFSR_W-1:0] lfsr_t;

  typedef struct packed {
    word_t word;
    lfsr_t state;
  } adv_t;

  // Register mask of the selected polynomial degree.
  function automatic lfsr_t poly_mask(logic [1:0] poly);
    case (poly)
      2'd0:    return 31'h0000_007F;
      2'd1:    return 31'h0000_7FFF;
      2'd2:    return 31'h007F_FFFF;
      default: return 31'h7FFF_FFFF;
    endcase
  endfunction

  // Advance a sequence by one full word; newest bit sits in state bit 0.
  function automatic adv_t prbs_adv(lfsr_t st, logic [1:0] poly);
    adv_t  r;
    lfsr_t s;
    word_t w;
    logic  b;
    s = st;
    w = '0;
    for (int i = 0; i < WORD_W; i++) begin
      case (poly)
        2'd0:    b = s[6]  ^ s[5];
        2'd1:    b = s[14] ^ s[13];
        2'd2:    b = s[22] ^ s[17];
        default: b = s[30] ^ s[27];
      endcase
      s = {s[LFSR_W-2:0], b};
      w = {w[WORD_W-2:0], b};
    end
    r.word  = w;
    r.state = s & poly_mask(poly);
    return r;
  endfunction

  function automatic word_t clk_word(logic blocky);
    return blocky ? 32'hFFFF_0000 : 32'hAAAA_AAAA;
  endfunction

  function automatic logic [POPC_W-1:0] popcnt(word_t v);
    logic [POPC_W-1:0] c;
    word_t             t;
    c = '0;
    t = v;
    for (int i = 0; i < WORD_W; i++) begin
      c = c + {{(POPC_W-1){1'b0}}, t[0]};
      t = t >> 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/bert_pattern_gen.sv
module bert_pattern_gen
  import bert_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       gen_rst,
  input  logic [2:0] sel,
  output word_t      tx_word
);
  lfsr_t st_q;
  lfsr_t st_ok;
  lfsr_t msk;
  adv_t  nx;

  always_comb begin
    msk   = poly_mask(sel[1:0]);
    // never run a sequence from an all-zero state
    st_ok = ((st_q & msk) == '0) ? msk : (st_q & msk);
    nx    = prbs_adv(st_ok, sel[1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst || gen_rst) begin
      st_q    <= '1;
      tx_word <= '0;
    end else begin
      st_q    <= nx.state;
      tx_word <= sel[2] ? clk_word(sel[0]) : nx.word;
    end
  end
endmodule

// File: rtl/bert_follower.sv
module bert_follower
  import bert_pkg::*;
#(
  parameter int LOCK_RUN  = 16,
  parameter int LOSS_ERRS = 8,
  parameter int LOSS_WIN  = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel,
  input  logic       rx_valid,
  input  word_t      rx_word,
  output logic       locked,
  output logic       acquire,
  output word_t      diff
);
  localparam int GW = $clog2(LOCK_RUN);
  localparam int EW = $clog2(LOSS_ERRS);
  localparam int WW = $clog2(LOSS_WIN);

  lfsr_t         st_q;
  logic [GW-1:0] good_q;
  logic [EW-1:0] werr_q;
  logic [WW-1:0] win_q;
  adv_t          adv;
  word_t         expect_w;
  lfsr_t         seed;
  logic          miss;
  logic          run_done;

  always_comb begin
    adv      = prbs_adv(st_q, sel[1:0]);
    expect_w = sel[2] ? clk_word(sel[0]) : adv.word;
    diff     = rx_word ^ expect_w;
    miss     = |diff;
    seed     = rx_word[LFSR_W-1:0] & poly_mask(sel[1:0]);
    run_done = (good_q == GW'(LOCK_RUN - 1));
    acquire  = rx_valid && !locked && !miss && run_done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= '0;
      locked <= 1'b0;
      good_q <= '0;
      werr_q <= '0;
      win_q  <= '0;
    end else if (rx_valid) begin
      if (!locked) begin
        if (miss) begin
          st_q   <= seed;
          good_q <= '0;
        end else begin
          st_q <= adv.state;
          if (run_done) begin
            locked <= 1'b1;
            good_q <= '0;
            werr_q <= '0;
            win_q  <= '0;
          end else begin
            good_q <= good_q + 1'b1;
          end
        end
      end else if (miss && (werr_q == EW'(LOSS_ERRS - 1))) begin
        locked <= 1'b0;
        st_q   <= seed;
        good_q <= '0;
      end else begin
        st_q <= adv.state;
        if (win_q == WW'(LOSS_WIN - 1)) begin
          win_q  <= '0;
          werr_q <= '0;
        end else begin
          win_q  <= win_q + 1'b1;
          werr_q <= werr_q + EW'(miss);
        end
      end
    end
  end
endmodule

// File: rtl/bert_stats.sv
module bert_stats
  import bert_pkg::*;
#(
  parameter int CNT_W       = 48,
  parameter int FRAME_WORDS = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             count_en,
  input  logic             restart,
  input  word_t            diff,
  output logic [CNT_W-1:0] bit_errs,
  output logic [CNT_W-1:0] frame_errs,
  output logic [CNT_W-1:0] total_bits,
  output logic             err_pulse
);
  localparam int FW = $clog2(FRAME_WORDS);

  logic [FW-1:0]     pos_q;
  logic              dirty_q;
  logic [POPC_W-1:0] nbits;
  logic              hit;
  logic              frame_end;

  function automatic logic [CNT_W-1:0] sat_add(logic [CNT_W-1:0] a,
                                               logic [CNT_W-1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CNT_W] ? '1 : s[CNT_W-1:0];
  endfunction

  always_comb begin
    nbits     = popcnt(diff);
    hit       = count_en && (nbits != '0);
    frame_end = (pos_q == FW'(FRAME_WORDS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      bit_errs   <= '0;
      frame_errs <= '0;
      total_bits <= '0;
      err_pulse  <= 1'b0;
      pos_q      <= '0;
      dirty_q    <= 1'b0;
    end else begin
      err_pulse <= hit;
      if (restart) begin
        pos_q   <= '0;
        dirty_q <= 1'b0;
      end else if (count_en) begin
        bit_errs   <= sat_add(bit_errs, CNT_W'(nbits));
        total_bits <= sat_add(total_bits, CNT_W'(WORD_W));
        if (frame_end) begin
          pos_q   <= '0;
          dirty_q <= 1'b0;
          if (dirty_q || hit) frame_errs <= sat_add(frame_errs, CNT_W'(1));
        end else begin
          pos_q   <= pos_q + 1'b1;
          dirty_q <= dirty_q || hit;
        end
      end
    end
  end
endmodule

// File: rtl/bert_engine.sv
module bert_engine
  import bert_pkg::*;
#(
  parameter int CNT_W       = 48,
  parameter int FRAME_WORDS = 1024,
  parameter int LOCK_RUN    = 16,
  parameter int LOSS_ERRS   = 8,
  parameter int LOSS_WIN    = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gen_rst,
  input  logic              stat_clr,
  input  logic [2:0]        pat_sel,
  input  logic [WORD_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic [WORD_W-1:0] tx_data,
  output logic [CNT_W-1:0]  bit_errs,
  output logic [CNT_W-1:0]  frame_errs,
  output logic [CNT_W-1:0]  total_bits,
  output logic              locked,
  output logic              err_pulse
);
  logic  acquire;
  word_t diff;

  bert_pattern_gen gen_i (
    .clk     (clk),
    .rst     (rst),
    .gen_rst (gen_rst),
    .sel     (pat_sel),
    .tx_word (tx_data)
  );

  bert_follower #(
    .LOCK_RUN  (LOCK_RUN),
    .LOSS_ERRS (LOSS_ERRS),
    .LOSS_WIN  (LOSS_WIN)
  ) fol_i (
    .clk      (clk),
    .rst      (rst),
    .sel      (pat_sel),
    .rx_valid (rx_valid),
    .rx_word  (rx_data),
    .locked   (locked),
    .acquire  (acquire),
    .diff     (diff)
  );

  bert_stats #(
    .CNT_W       (CNT_W),
    .FRAME_WORDS (FRAME_WORDS)
  ) stat_i (
    .clk        (clk),
    .rst        (rst),
    .clr        (stat_clr),
    .count_en   (rx_valid && locked),
    .restart    (acquire),
    .diff       (diff),
    .bit_errs   (bit_errs),
    .frame_errs (frame_errs),
    .total_bits (total_bits),
    .err_pulse  (err_pulse)
  );
endmodule

// File: rtl/bert_engine_chk.sv
module bert_engine_chk #(
  parameter int CNT_W = 48
) (
  input logic             clk,
  input logic             rst,
  input logic             stat_clr,
  input logic             rx_valid,
  input logic             locked,
  input logic             err_pulse,
  input logic [CNT_W-1:0] bit_errs,
  input logic [CNT_W-1:0] frame_errs,
  input logic [CNT_W-1:0] total_bits
);
  // R8
  pulse_from_locked_word_chk: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> ($past(locked) && $past(rx_valid)));

  // R12
  idle_cycle_holds_counts_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rx_valid) && !$past(stat_clr)) |-> ($stable(total_bits) && $stable(bit_errs)));

  // R10
  total_never_falls_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(stat_clr) |-> (total_bits >= $past(total_bits)));

  // R11
  clear_zeroes_counts_chk: assert property (@(posedge clk) disable iff (rst)
    $past(stat_clr) |-> (bit_errs == '0 && frame_errs == '0 && total_bits == '0));

  // R4
  lock_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(rx_valid));
endmodule

bind bert_engine bert_engine_chk #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .stat_clr   (stat_clr),
  .rx_valid   (rx_valid),
  .locked     (locked),
  .err_pulse  (err_pulse),
  .bit_errs   (bit_errs),
  .frame_errs (frame_errs),
  .total_bits (total_bits)
);

// File: tb/bert_engine_tb_top.sv
module bert_engine_tb_top;
  localparam int CLK_P = 10;
  localparam int CW    = 12;
  localparam int FRW   = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          gen_rst = 1'b0;
  logic          stat_clr = 1'b0;
  logic [2:0]    pat_sel = 3'd0;
  logic [31:0]   rx_data = '0;
  logic          rx_valid = 1'b0;
  logic [31:0]   tx_data;
  logic [CW-1:0] bit_errs, frame_errs, total_bits;
  logic          locked, err_pulse;

  int n_tests = 0;
  int n_fail  = 0;
  int mn = 7, mt = 6;
  logic [30:0] bst;

  always #(CLK_P/2) clk = ~clk;

  bert_engine #(.CNT_W(CW), .FRAME_WORDS(FRW)) dut_i (
    .clk(clk), .rst(rst), .gen_rst(gen_rst), .stat_clr(stat_clr),
    .pat_sel(pat_sel), .rx_data(rx_data), .rx_valid(rx_valid),
    .tx_data(tx_data), .bit_errs(bit_errs), .frame_errs(frame_errs),
    .total_bits(total_bits), .locked(locked), .err_pulse(err_pulse));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [30:0] m_mask(int n);
    return 31'((64'd1 << n) - 64'd1);
  endfunction

  // Bit-serial model: x(k) = x(k-n) ^ x(k-t), history newest at bit 0.
  function automatic logic [31:0] m_step(inout logic [30:0] st, input int n, input int t);
    logic [62:0] h, x;
    logic [31:0] w;
    h = 63'(st);
    w = '0;
    for (int i = 0; i < 32; i++) begin
      x = (h >> (n - 1)) ^ (h >> (t - 1));
      h = {h[61:0], x[0]};
      w = {w[30:0], x[0]};
    end
    st = h[30:0] & m_mask(n);
    return w;
  endfunction

  task automatic set_poly(int p);
    case (p)
      0: begin mn = 7;  mt = 6;  end
      1: begin mn = 15; mt = 14; end
      2: begin mn = 23; mt = 18; end
      default: begin mn = 31; mt = 28; end
    endcase
    pat_sel = 3'(p);
  endtask

  function automatic logic [31:0] good();
    return m_step(bst, mn, mt);
  endfunction

  task automatic send(logic [31:0] w, logic v);
    @(negedge clk);
    rx_data  = w;
    rx_valid = v;
    @(posedge clk);
    #1;
    rx_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic lock_up(int p);
    do_reset();
    set_poly(p);
    bst = 31'h1234567 & m_mask(mn);
    send(good(), 1'b1);
    repeat (16) send(good(), 1'b1);
    chk("R4 lock after run", 64'(locked), 64'd1);
  endtask

  task automatic t_reset();
    chk("R13 tx zero", 64'(tx_data), 64'd0);
    chk("R13 unlocked", 64'(locked), 64'd0);
    chk("R13 bit_errs", 64'(bit_errs), 64'd0);
    chk("R13 frame_errs", 64'(frame_errs), 64'd0);
    chk("R13 total_bits", 64'(total_bits), 64'd0);
    chk("R13 err_pulse", 64'(err_pulse), 64'd0);
  endtask

  task automatic t_tx_prbs(int p);
    logic [30:0] st;
    logic [31:0] e;
    set_poly(p);
    @(negedge clk); gen_rst = 1'b1;
    @(posedge clk); #1;
    chk("R3 tx held at zero", 64'(tx_data), 64'd0);
    @(negedge clk); gen_rst = 1'b0;
    st = m_mask(mn);
    @(posedge clk); #1;
    e = m_step(st, mn, mt);
    chk("R3 first word from all-ones", 64'(tx_data), 64'(e));
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      e = m_step(st, mn, mt);
      chk("R1 sequence continues", 64'(tx_data), 64'(e));
    end
  endtask

  task automatic t_tx_clk();
    logic [31:0] exp_w [4];
    exp_w[0] = 32'hAAAA_AAAA; exp_w[1] = 32'hFFFF_0000;
    exp_w[2] = 32'hAAAA_AAAA; exp_w[3] = 32'hFFFF_0000;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); pat_sel = 3'(4 + c);
      @(posedge clk); #1;
      chk("R2 clock word", 64'(tx_data), 64'(exp_w[c]));
      @(posedge clk); #1;
      chk("R2 clock word repeats", 64'(tx_data), 64'(exp_w[c]));
    end
  endtask

  task automatic t_lock_count_frames();
    do_reset();
    set_poly(1);
    bst = 31'h0000_4321;
    send(good(), 1'b1);
    chk("R8 no pulse while unlocked", 64'(err_pulse), 64'd0);
    repeat (15) send(good(), 1'b1);
    chk("R4 not yet locked at 15", 64'(locked), 64'd0);
    send(good(), 1'b1);
    chk("R4 locked at 16", 64'(locked), 64'd1);
    chk("R6 nothing counted before lock", 64'(bit_errs), 64'd0);
    chk("R7 no bits before lock", 64'(total_bits), 64'd0);
    send(good(), 1'b1);
    chk("R8 clean word no pulse", 64'(err_pulse), 64'd0);
    chk("R7 one word", 64'(total_bits), 64'd32);
    send(good() ^ 32'h0000_0007, 1'b1);
    chk("R8 pulse on error", 64'(err_pulse), 64'd1);
    chk("R6 three bits", 64'(bit_errs), 64'd3);
    chk("R7 two words", 64'(total_bits), 64'd64);
    send(good() ^ 32'h8000_0001, 1'b1);
    chk("R6 two more bits", 64'(bit_errs), 64'd5);
    send(good(), 1'b1);
    chk("R8 pulse one cycle only", 64'(err_pulse), 64'd0);
    repeat (27) send(good(), 1'b1);
    chk("R9 frame not yet closed", 64'(frame_errs), 64'd0);
    send(good(), 1'b1);
    chk("R9 errored frame counted", 64'(frame_errs), 64'd1);
    repeat (32) send(good(), 1'b1);
    chk("R9 clean frame not counted", 64'(frame_errs), 64'd1);
    repeat (31) send(good(), 1'b1);
    send(good() ^ 32'h0000_0001, 1'b1);
    chk("R9 error on last word", 64'(frame_errs), 64'd2);
    chk("R6 total bit errors", 64'(bit_errs), 64'd6);
    chk("R7 96 words", 64'(total_bits), 64'd3072);
    // R12 gap with garbage data
    repeat (5) send(32'hDEAD_BEEF, 1'b0);
    chk("R12 bits held", 64'(total_bits), 64'd3072);
    chk("R12 errors held", 64'(bit_errs), 64'd6);
    chk("R12 lock held", 64'(locked), 64'd1);
    send(good(), 1'b1);
    chk("R12 prediction not advanced", 64'(err_pulse), 64'd0);
    chk("R12 counting resumes", 64'(total_bits), 64'd3104);
  endtask

  task automatic t_loss();
    lock_up(2);
    repeat (7) send(good() ^ 32'h0000_0001, 1'b1);
    chk("R5 seven errors keep lock", 64'(locked), 64'd1);
    send(good() ^ 32'h0000_0001, 1'b1);
    chk("R5 eighth error drops lock", 64'(locked), 64'd0);
    chk("R6 losing word counted", 64'(bit_errs), 64'd8);
    send(good(), 1'b1);
    repeat (15) send(good(), 1'b1);
    chk("R4 relock not yet", 64'(locked), 64'd0);
    send(good(), 1'b1);
    chk("R4 relocked after reseed", 64'(locked), 64'd1);
  endtask

  task automatic t_window();
    lock_up(3);
    repeat (7) send(good() ^ 32'h0000_0100, 1'b1);
    repeat (57) send(good(), 1'b1);
    repeat (7) send(good() ^ 32'h0000_0100, 1'b1);
    chk("R5 window boundary clears errors", 64'(locked), 64'd1);
    send(good() ^ 32'h0000_0100, 1'b1);
    chk("R5 eighth in second window", 64'(locked), 64'd0);
  endtask

  task automatic t_sat_clr();
    lock_up(0);
    repeat (127) send(good(), 1'b1);
    chk("R10 below limit", 64'(total_bits), 64'd4064);
    send(good(), 1'b1);
    chk("R10 saturates", 64'(total_bits), 64'd4095);
    repeat (2) send(good(), 1'b1);
    chk("R10 stays saturated", 64'(total_bits), 64'd4095);
    @(negedge clk); stat_clr = 1'b1;
    @(posedge clk); #1; stat_clr = 1'b0;
    chk("R11 total cleared", 64'(total_bits), 64'd0);
    chk("R11 lock kept", 64'(locked), 64'd1);
    send(good(), 1'b1);
    chk("R11 prediction kept", 64'(err_pulse), 64'd0);
    chk("R11 counting after clear", 64'(total_bits), 64'd32);
  endtask

  task automatic t_clock_rx();
    do_reset();
    pat_sel = 3'd5;
    repeat (15) send(32'hFFFF_0000, 1'b1);
    chk("R2 R4 clock not yet locked", 64'(locked), 64'd0);
    send(32'hFFFF_0000, 1'b1);
    chk("R2 R4 clock locked", 64'(locked), 64'd1);
    send(32'hFFFF_0001, 1'b1);
    chk("R2 R6 clock bit error", 64'(bit_errs), 64'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    for (int p = 0; p < 4; p++) t_tx_prbs(p);
    t_tx_clk();
    t_lock_count_frames();
    t_loss();
    t_window();
    t_sat_clr();
    t_clock_rx();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule